// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-pin serial slave that gives a host write and read access to a bank of seven 11-bit configuration registers. The host drives a serial clock, an active-low select and a data line. While select is low, each rising clock edge samples one bit into a 15-bit frame. The first rising edge seen with select high closes the frame and acts on it. A write frame updates the addressed register. A read frame loads the addressed register and its address into the shift register. The next select-low frame then shifts them back out on the same data line, which the port drives for the length of that frame.

The register bank is clocked by the serial clock and comes out of reset holding fixed power-up values. Every register bit is brought out as a flat vector for the logic that uses it. The data pin is split into an input, an output and an output enable, so that a pad cell or the chip top can merge them onto one wire. What each register field controls is outside this block.

Top module: `serprog_slave`

## Requirements
- R1: During and after synchronous reset (rst_n low on a rising sclk edge), the registers at addresses 0..6 hold 0x04F, 0x003, 0x006, 0x013, 0x5DC, 0x5C1 and 0x047, and sdata_oe is 0.
- R2: A frame is the run of rising sclk edges that sample sel_n low. Its first bit is the direction flag (0 = write, 1 = read). The next 3 bits are the address, least significant bit first, and the last 11 bits are the data, least significant bit first.
- R3: A write frame of exactly 15 bits updates the addressed register on the first rising edge that samples sel_n high. The new value is visible on cfg_regs (register n at bits n*11 to n*11+10) after that edge, and no other register changes.
- R4: A read frame of exactly 15 bits sets sdata_oe on its closing edge. sdata_out then presents address bit 0 before the first edge of the next select-low frame. Each rising edge of that frame advances one bit: the 3 address bits first, then the 11 data bits, each least significant bit first. sdata_oe stays high until that frame closes.
- R5: A frame with any bit count other than 15 commits nothing: no register changes and sdata_oe stays 0.
- R6: The closing edge of a read-out frame clears sdata_oe and writes no register, and sdata_in is ignored during the read-out frame.
- R7: A write to address 7 changes no register. A read of address 7 returns address 7 and zero data.
- R8: The bit count restarts at each new select-low frame, so a complete frame that follows an aborted one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low frame select |
| sdata_in | input | 1 | Serial data from the host |
| sdata_out | output | 1 | Serial read-back data |
| sdata_oe | output | 1 | Drive enable for sdata_out onto the shared data wire |
| cfg_regs | output | 77 | Register bank, register n at bits n*11 to n*11+10 |

## Verification
The hardest state to reach is the closing edge of a read-out frame. On that edge the shift register still holds bits that could be mistaken for a write command, and the port must release the data line without committing them. The stimulus reaches it by issuing a read frame and then clocking the full 14-bit read-out frame while toggling sdata_in. Before any other traffic, the bench checks that sdata_oe has dropped and that the bank is unchanged. Frames of 14 and 16 bits, and a 6-bit aborted frame followed by a full frame, cover the bit-count decisions around the closing edge.

// File: rtl/serprog_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and reset values of the serial register port.
// Assumes 11-bit registers; reset values are built field by field.
package serprog_pkg;

    localparam int CFG_DATA_W = 11;
    localparam int CFG_ADDR_W = 3;
    localparam int CFG_NREGS  = 7;

    // Power-up value of register idx, composed from its fields (MSB first)
    function automatic logic [CFG_DATA_W-1:0] reg_default(input int idx);
        logic [CFG_DATA_W-1:0] v;
        case (idx)
            0: v = 11'h04F;                         // feedback modulus 80
            1: v = 11'h003;                         // sync pulse low state
            2: v = 11'h006;                         // sync pulse high state
            3: v = {1'b0, 10'h013};                 // edge polarity, ref modulus 20
            4: v = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 3'd4};
            5: v = {1'b1, 1'b0, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1};
            6: v = {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7};
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/serprog_framer.sv
`timescale 1ns/1ps
// Module: frame tracker. Watches select on each rising serial clock edge,
// flags the first bit of a frame and the closing edge, and counts frame bits.
// Assumes select is sampled only on sclk rising edges.
module serprog_framer #(
    parameter int FRAME_W = 15
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic sel_n,
    output logic shift_en,
    output logic close_edge,
    output logic frame_full
);
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_SAT = FRAME_W + 1;

    logic             sel_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             frame_start;

    assign shift_en    = !sel_n;
    assign frame_start = !sel_n && sel_q;
    assign close_edge  = sel_n && !sel_q;
    assign frame_full  = (bit_cnt == CNT_W'(FRAME_W));

    // Purpose: remember the select level sampled on the previous edge
    always_ff @(posedge sclk) begin
        if (!rst_n) sel_q <= 1'b1;
        else        sel_q <= sel_n;
    end

    // Purpose: count bits of the current frame, restarting at each frame start
    always_ff @(posedge sclk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (frame_start)
            bit_cnt <= CNT_W'(1);
        else if (shift_en && bit_cnt != CNT_W'(CNT_SAT))
            bit_cnt <= bit_cnt + CNT_W'(1);
    end

endmodule

// File: rtl/serprog_shifter.sv
`timescale 1ns/1ps
// Module: frame shift register and read-out driver. Shifts toward bit 0,
// new bits enter at the top; on a read commit it is reloaded with
// {pad, data, address} and bit 0 drives the data line while enabled.
module serprog_shifter #(
    parameter int DATA_W = 11,
    parameter int ADDR_W = 3
) (
    input  logic                      sclk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic                      load_rd,
    input  logic                      release_oe,
    input  logic                      sdata_in,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [DATA_W-1:0]         rd_data,
    output logic [DATA_W+ADDR_W:0]    frame,
    output logic                      sdata_out,
    output logic                      sdata_oe
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    logic [FRAME_W-1:0] sr;
    logic               oe_q;

    // Purpose: capture host bits, or reload and shift out read-back data
    always_ff @(posedge sclk) begin
        if (!rst_n)
            sr <= '0;
        else if (load_rd)
            sr <= {1'b0, rd_data, rd_addr};
        else if (shift_en)
            sr <= {(oe_q ? 1'b0 : sdata_in), sr[FRAME_W-1:1]};
    end

    // Purpose: own the data line from read commit until read-out frame closes
    always_ff @(posedge sclk) begin
        if (!rst_n)          oe_q <= 1'b0;
        else if (load_rd)    oe_q <= 1'b1;
        else if (release_oe) oe_q <= 1'b0;
    end

    assign frame     = sr;
    assign sdata_out = oe_q & sr[0];
    assign sdata_oe  = oe_q;

endmodule

// File: rtl/serprog_regbank.sv
`timescale 1ns/1ps
// Module: configuration register bank with power-up values from the package.
// Addresses at or above NUM_REGS hold nothing: writes drop, reads give zero.
module serprog_regbank
    import serprog_pkg::*;
#(
    parameter int DATA_W   = 11,
    parameter int ADDR_W   = 3,
    parameter int NUM_REGS = 7
) (
    input  logic                       sclk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Purpose: hold register g, loading its default in reset
        always_ff @(posedge sclk) begin
            if (!rst_n)
                regs[g] <= DATA_W'(reg_default(g));
            else if (wr_en && addr == ADDR_W'(g))
                regs[g] <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    // Purpose: read mux with zero for unpopulated addresses
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr == ADDR_W'(i)) rdata = regs[i];
    end

endmodule

// File: rtl/serprog_slave.sv
`timescale 1ns/1ps
// Module: three-pin serial register port (top). A 15-bit frame is sampled
// while sel_n is low; the first edge with sel_n high commits it. A read
// commit turns the port into a talker for the following frame.
// Assumes sclk is the only clock and rst_n is synchronous to it.
module serprog_slave
    import serprog_pkg::*;
#(
    parameter int DATA_W   = CFG_DATA_W,
    parameter int ADDR_W   = CFG_ADDR_W,
    parameter int NUM_REGS = CFG_NREGS
) (
    input  logic                       sclk,
    input  logic                       rst_n,
    input  logic                       sel_n,
    input  logic                       sdata_in,
    output logic                       sdata_out,
    output logic                       sdata_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int FLAT_W  = NUM_REGS * DATA_W;

    logic               shift_en, close_edge, frame_full;
    logic               commit, wr_en, load_rd, release_oe;
    logic [FRAME_W-1:0] frame;
    logic               rw_flag;
    logic [ADDR_W-1:0]  f_addr;
    logic [DATA_W-1:0]  f_data, rd_data;

    serprog_framer #(.FRAME_W(FRAME_W)) framer_i (
        .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n),
        .shift_en(shift_en), .close_edge(close_edge), .frame_full(frame_full)
    );

    // Frame field split: flag at bit 0, address next, data on top
    assign rw_flag = frame[0];
    assign f_addr  = frame[ADDR_W:1];
    assign f_data  = frame[FRAME_W-1:ADDR_W+1];

    // Purpose: decide what the closing edge does
    always_comb begin
        commit     = close_edge && !sdata_oe && frame_full;
        wr_en      = commit && !rw_flag;
        load_rd    = commit && rw_flag;
        release_oe = close_edge && sdata_oe;
    end

    serprog_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) shifter_i (
        .sclk(sclk), .rst_n(rst_n), .shift_en(shift_en), .load_rd(load_rd),
        .release_oe(release_oe), .sdata_in(sdata_in), .rd_addr(f_addr),
        .rd_data(rd_data), .frame(frame), .sdata_out(sdata_out),
        .sdata_oe(sdata_oe)
    );

    serprog_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) bank_i (
        .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .addr(f_addr),
        .wdata(f_data), .rdata(rd_data), .regs_flat(cfg_regs)
    );

endmodule

// File: rtl/serprog_checker.sv
`timescale 1ns/1ps
// Module: protocol checker bound to serprog_slave; observes ports only.
module serprog_checker #(
    parameter int FLAT_W = 77
) (
    input logic              sclk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sdata_oe,
    input logic [FLAT_W-1:0] cfg_regs
);
    // Registers change only on a closing edge (sel low then high)
    assert_write_on_close_R3: assert property (@(posedge sclk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> ($past(sel_n) && !$past(sel_n, 2)));

    // Output enable rises only as the result of a closing edge
    assert_oe_rise_on_close_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(sdata_oe) |-> ($past(sel_n) && !$past(sel_n, 2)));

    // Output enable holds through the read-out frame
    assert_oe_hold_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        (sdata_oe && !sel_n) |=> sdata_oe);

    // Output enable drops only on the read-out frame's closing edge
    assert_oe_release_R6: assert property (@(posedge sclk) disable iff (!rst_n)
        $fell(sdata_oe) |-> ($past(sel_n) && !$past(sel_n, 2)));

    // No register write while the port is talking
    assert_no_write_readout_R6: assert property (@(posedge sclk) disable iff (!rst_n)
        ($past(sdata_oe) && $past(sel_n)) |-> $stable(cfg_regs));
endmodule

bind serprog_slave serprog_checker #(.FLAT_W(FLAT_W)) chk_i (
    .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n),
    .sdata_oe(sdata_oe), .cfg_regs(cfg_regs)
);

// File: tb/serprog_slave_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios against the serial register port.
module serprog_slave_tb_top;
    localparam int DW = 11;
    localparam int AW = 3;
    localparam int NR = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sdata_in = 1'b0;
    logic sdata_out, sdata_oe;
    logic [NR*DW-1:0] cfg_regs;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] model [NR];

    always #2 clk = ~clk;

    serprog_slave dut_i (
        .sclk(clk), .rst_n(rst_n), .sel_n(sel_n), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .cfg_regs(cfg_regs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_bank(input string tag);
        for (int i = 0; i < NR; i++)
            chk(tag, 32'(cfg_regs[i*DW +: DW]), 32'(model[i]));
    endtask

    // Send n bits of word LSB first with sel low, then one closing edge
    task automatic send_frame(input logic [15:0] word, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sel_n = 1'b0; sdata_in = word[i];
        end
        @(negedge clk); sel_n = 1'b1; sdata_in = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d);
        return {1'b0, d, a, rw};
    endfunction

    // Clock out the 14-bit read-out frame, toggling sdata_in to be ignored
    task automatic read_out(output logic [13:0] got);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk); got[i] = sdata_out; sel_n = 1'b0; sdata_in = i[0];
        end
        @(negedge clk); sel_n = 1'b1; sdata_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d, input string tag);
        logic [13:0] got;
        send_frame(mk(1'b1, a, '0), 15);
        chk({tag, " R4 oe after read commit"}, 32'(sdata_oe), 1);
        read_out(got);
        chk({tag, " R4 read-out address"}, 32'(got[2:0]), 32'(a));
        chk({tag, " R4 read-out data"}, 32'(got[13:3]), 32'(exp_d));
        chk({tag, " R6 oe released"}, 32'(sdata_oe), 0);
        chk_bank({tag, " R6 bank untouched by read-out"});
    endtask

    task automatic test_reset();
        model[0] = 11'h04F; model[1] = 11'h003; model[2] = 11'h006; model[3] = 11'h013;
        model[4] = 11'h5DC; model[5] = 11'h5C1; model[6] = 11'h047;
        chk_bank("R1 reset value");
        chk("R1 oe in reset", 32'(sdata_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bank("R1 value after reset release");
    endtask

    task automatic test_write();
        send_frame(mk(1'b0, 3'd2, 11'h5A3), 15); model[2] = 11'h5A3;
        chk_bank("R2 R3 write reg2");
        send_frame(mk(1'b0, 3'd1, 11'h001), 15); model[1] = 11'h001;
        chk_bank("R2 R3 write reg1 lsb order");
        send_frame(mk(1'b0, 3'd6, 11'h400), 15); model[6] = 11'h400;
        chk_bank("R2 R3 write reg6 msb");
        chk("R3 oe stays low on write", 32'(sdata_oe), 0);
    endtask

    task automatic test_read();
        do_read(3'd4, 11'h5DC, "read reg4");
        do_read(3'd2, 11'h5A3, "read reg2");
        do_read(3'd1, 11'h001, "read reg1");
    endtask

    task automatic test_addr7();
        send_frame(mk(1'b0, 3'd7, 11'h7FF), 15);
        chk_bank("R7 write addr7 ignored");
        do_read(3'd7, 11'h000, "R7 read addr7");
    endtask

    task automatic test_bad_length();
        send_frame(mk(1'b0, 3'd0, 11'h123), 14);
        chk_bank("R5 14-bit frame ignored");
        chk("R5 oe after short frame", 32'(sdata_oe), 0);
        send_frame(16'hFFFF, 16);
        chk_bank("R5 16-bit frame ignored");
        send_frame(mk(1'b1, 3'd3, '0), 14);
        chk("R5 short read frame no oe", 32'(sdata_oe), 0);
    endtask

    task automatic test_restart();
        send_frame(16'h003F, 6);
        chk_bank("R8 aborted frame no effect");
        send_frame(mk(1'b0, 3'd0, 11'h2AA), 15); model[0] = 11'h2AA;
        chk_bank("R8 full frame after abort");
        do_read(3'd0, 11'h2AA, "R8 readback");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_write();
        test_read();
        test_addr7();
        test_bad_length();
        test_restart();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule